// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller with Return-Address Stack

This block arbitrates between three interrupt sources of a small 8-bit core: a falling edge on an external request line and two single-cycle overflow strobes from timers. One byte-wide control register holds a master enable, one enable per source and one pending flag per source. Software reads and writes this register. The core raises an instruction-phase strobe once per instruction. On that strobe the block picks the highest-priority enabled pending source. It then acknowledges it, hands back the service address and saves the current program counter.

The return-address stack is part of the block. It has sixteen entries and holds 13-bit addresses. The core pushes to it on subroutine calls and pops from it on returns. When the stack is full, the block does not grant an interrupt, and the request stays pending until a return frees an entry. A call made while the stack is full still completes: it drops the oldest saved address. A return from interrupt also turns the master enable back on.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the control register reads 00h, `ack` is low and `top_pc` is 000h.
- R2: Register layout: bit0 master enable, bit1/bit2/bit3 enable external/timer0/timer1, bit4/bit5/bit6 pending flag external/timer0/timer1, bit7 always reads 0. A write stores bits 6..0, and writing 1 to a flag bit sets that flag.
- R3: A high-to-low change on `ext_line` sets bit4. A low-to-high change sets nothing.
- R4: A pulse on `tmr0_ovf` sets bit5 and a pulse on `tmr1_ovf` sets bit6. The flag is readable in the cycle after the pulse.
- R5: `ack` is high only in a cycle with `phase_stb` high, the master enable set, at least one source both enabled and flagged, the stack not full, and no call or return command. Pending requests that arrive between strobes are resolved only at the next strobe.
- R6: When several sources qualify, the external source wins over timer0, and timer0 wins over timer1. `vec_addr` is 004h, 008h or 00Ch respectively.
- R7: An acknowledge clears the serviced flag and the master enable and leaves the other flags unchanged. It also pushes `pc_now`, which `top_pc` shows from the next cycle on.
- R8: While sixteen addresses are held, no acknowledge occurs and the flag stays set. After one return, the next strobe acknowledges.
- R9: `reti_req` pops the stack and sets the master enable. `ret_req` pops it and leaves the master enable unchanged.
- R10: `call_req` pushes `pc_now`. A seventeenth push discards the oldest entry, so the 16 most recent addresses come back newest first.
- R11: With the stack empty, `top_pc` is 000h, and a return leaves the stack empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ext_line | input | 1 | External request line, already synchronised |
| tmr0_ovf | input | 1 | Timer0 overflow pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| phase_stb | input | 1 | Instruction-phase sampling strobe |
| call_req | input | 1 | Subroutine call, pushes `pc_now` |
| ret_req | input | 1 | Plain return, pops |
| reti_req | input | 1 | Return from interrupt, pops and sets master enable |
| pc_now | input | 13 | Program counter to save |
| ack | output | 1 | Interrupt acknowledge |
| vec_addr | output | 13 | Service address of the granted source |
| top_pc | output | 13 | Address a return would restore (top of stack) |

## Verification
The assertions assume that the core never issues a call together with a return, and never writes the control register in the cycle it issues a return from interrupt. The bench follows both rules by driving only one command per cycle. Under these rules, every acknowledge can be checked against the stack top in the following cycle. The sweep covers all 64 combinations of pending flags and enables with the master enable set. It also runs dedicated sequences for the full-stack hold, the oldest-entry drop and pops from an empty stack.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 3;
  localparam int PCW   = 13;
  localparam int DEPTH = 16;

  // Service address for source index idx: 4 * (idx + 1)
  function automatic logic [PCW-1:0] vec_of(input int idx);
    return PCW'((idx + 1) * 4);
  endfunction

  // One-hot grant, lowest index has the highest priority
  function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] g;
    g = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) g = NSRC'(1) << i;
    return g;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int NSRC = irq_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2*NSRC:0] wdata,
  input  logic [NSRC-1:0] evt,
  input  logic            ack,
  input  logic [NSRC-1:0] grant,
  input  logic            reti,
  output logic            master,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flag
);
  logic            master_n;
  logic [NSRC-1:0] en_n, flag_n;

  always_comb begin
    master_n = we ? wdata[0] : master;
    en_n     = we ? wdata[NSRC:1] : en;
    flag_n   = we ? wdata[2*NSRC:NSRC+1] : flag;
    if (ack) begin
      master_n = 1'b0;
      flag_n   = flag_n & ~grant;
    end
    flag_n = flag_n | evt;
    if (reti) master_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master <= 1'b0;
      en     <= '0;
      flag   <= '0;
    end else begin
      master <= master_n;
      en     <= en_n;
      flag   <= flag_n;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int NSRC = irq_pkg::NSRC,
  parameter int PCW  = irq_pkg::PCW
) (
  input  logic            stb,
  input  logic            master,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] flag,
  input  logic            stk_full,
  input  logic            busy,
  output logic            ack,
  output logic [NSRC-1:0] grant,
  output logic [PCW-1:0]  vec
);
  logic [NSRC-1:0] req;

  assign req   = en & flag;
  assign grant = irq_pkg::pick_first(req);
  assign ack   = stb & master & (|req) & ~stk_full & ~busy;

  always_comb begin
    vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vec = irq_pkg::vec_of(i);
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = irq_pkg::DEPTH,
  parameter int W     = irq_pkg::PCW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] CMAX = CNTW'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wp;
  logic [CNTW-1:0] cnt;
  logic [PTRW-1:0] rp;

  assign rp   = wp - PTRW'(1);
  assign full = (cnt == CMAX);
  assign top  = (cnt == '0) ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push) begin
      wp <= wp + PTRW'(1);
      if (!full) cnt <= cnt + CNTW'(1);
    end else if (pop && cnt != '0) begin
      wp  <= rp;
      cnt <= cnt - CNTW'(1);
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
  parameter int NSRC  = irq_pkg::NSRC,
  parameter int PCW   = irq_pkg::PCW,
  parameter int DEPTH = irq_pkg::DEPTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           ext_line,
  input  logic           tmr0_ovf,
  input  logic           tmr1_ovf,
  input  logic           phase_stb,
  input  logic           call_req,
  input  logic           ret_req,
  input  logic           reti_req,
  input  logic [PCW-1:0] pc_now,
  output logic           ack,
  output logic [PCW-1:0] vec_addr,
  output logic [PCW-1:0] top_pc
);
  localparam int REGW = 2 * NSRC + 1;

  logic            ext_q, ext_fall;
  logic            master, stk_full, busy, push, pop;
  logic [NSRC-1:0] en, flag, grant, evt;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_line;
  end
  assign ext_fall = ext_q & ~ext_line;
  assign evt      = {tmr1_ovf, tmr0_ovf, ext_fall};

  assign busy = call_req | ret_req | reti_req;
  assign push = ack | call_req;
  assign pop  = (ret_req | reti_req) & ~call_req;

  irq_regs #(.NSRC(NSRC)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata[REGW-1:0]),
    .evt(evt), .ack(ack), .grant(grant), .reti(reti_req),
    .master(master), .en(en), .flag(flag)
  );

  irq_arb #(.NSRC(NSRC), .PCW(PCW)) arb_i (
    .stb(phase_stb), .master(master), .en(en), .flag(flag),
    .stk_full(stk_full), .busy(busy), .ack(ack), .grant(grant), .vec(vec_addr)
  );

  ret_stack #(.DEPTH(DEPTH), .W(PCW)) stk_i (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(pc_now),
    .top(top_pc), .full(stk_full)
  );

  assign reg_rdata = 8'({flag, en, master});
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int PCW = irq_pkg::PCW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ack,
  input logic           phase_stb,
  input logic [PCW-1:0] vec_addr,
  input logic [7:0]     reg_rdata,
  input logic [PCW-1:0] pc_now,
  input logic [PCW-1:0] top_pc,
  input logic           ext_fall,
  input logic           tmr0_ovf,
  input logic           tmr1_ovf,
  input logic           reti_req,
  input logic           stk_full
);
  // R5
  ack_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> phase_stb);
  // R6
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (vec_addr == 13'h004 || vec_addr == 13'h008 || vec_addr == 13'h00C));
  // R7
  ack_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !reg_rdata[0]);
  // R7
  ack_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> top_pc == $past(pc_now));
  // R8
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !ack);
  // R3
  ext_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fall |=> reg_rdata[4]);
  // R4
  t0_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_ovf |=> reg_rdata[5]);
  // R4
  t1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr1_ovf |=> reg_rdata[6]);
  // R9
  reti_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reti_req |=> reg_rdata[0]);
  // R2
  bit7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7] == 1'b0);
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.PCW(PCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .phase_stb(phase_stb),
  .vec_addr(vec_addr), .reg_rdata(reg_rdata), .pc_now(pc_now), .top_pc(top_pc),
  .ext_fall(ext_fall), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
  .reti_req(reti_req), .stk_full(stk_full)
);

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 0, ext_line = 1, tmr0_ovf = 0, tmr1_ovf = 0, phase_stb = 0;
  logic        call_req = 0, ret_req = 0, reti_req = 0;
  logic [7:0]  reg_wdata = 0, reg_rdata;
  logic [12:0] pc_now = 0, vec_addr, top_pc;
  logic        ack;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_ctrl_top dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1; reg_wdata = v; step; reg_we = 0;
  endtask

  task automatic cmd_call(input logic [12:0] pc);
    call_req = 1; pc_now = pc; step; call_req = 0;
  endtask

  task automatic cmd_ret;  ret_req = 1;  step; ret_req = 0;  endtask
  task automatic cmd_reti; reti_req = 1; step; reti_req = 0; endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [2:0]  req, g;
    logic [12:0] ev;
    repeat (3) step;
    rst_n = 1; step;
    // R1
    chk(reg_rdata == 0, "R1 reg", reg_rdata, 0);
    chk(top_pc == 0,    "R1 top", top_pc, 0);
    chk(ack == 0,       "R1 ack", ack, 0);

    // R2 all write values read back with bit7 forced 0
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      chk(reg_rdata == (8'(v) & 8'h7F), "R2", reg_rdata, v & 'h7F);
    end
    wr(8'h00);

    // R3 falling edge sets, rising does not
    ext_line = 0; step; step;
    chk(reg_rdata[4] == 1, "R3 fall", reg_rdata, 'h10);
    wr(8'h00);
    ext_line = 1; step; step;
    chk(reg_rdata[4] == 0, "R3 rise", reg_rdata, 0);

    // R4 timer strobes
    tmr0_ovf = 1; step; tmr0_ovf = 0;
    chk(reg_rdata == 8'h20, "R4 t0", reg_rdata, 'h20);
    tmr1_ovf = 1; step; tmr1_ovf = 0;
    chk(reg_rdata == 8'h60, "R4 t1", reg_rdata, 'h60);

    // R5 no strobe, no acknowledge; R5 master off, no acknowledge
    wr(8'h7E); step;
    chk(ack == 0 && reg_rdata == 8'h7E, "R5 nostb", reg_rdata, 'h7E);
    phase_stb = 1; #1;
    chk(ack == 0, "R5 masked", ack, 0);
    phase_stb = 0; step;

    // R5 R6 R7 sweep over flags and enables
    for (int f = 0; f < 8; f++) begin
      for (int e = 0; e < 8; e++) begin
        wr({1'b0, 3'(f), 3'(e), 1'b1});
        req = 3'(f & e);
        g   = req[0] ? 3'b001 : req[1] ? 3'b010 : req[2] ? 3'b100 : 3'b000;
        ev  = req[0] ? 13'h004 : req[1] ? 13'h008 : 13'h00C;
        pc_now = 13'(f * 8 + e + 13'h100);
        phase_stb = 1; #1;
        chk(ack == (req != 0), "R5 ack", ack, req != 0);
        if (req != 0) chk(vec_addr == ev, "R6 vec", vec_addr, ev);
        step; phase_stb = 0;
        if (req != 0) begin
          chk(reg_rdata == {1'b0, 3'(f) & ~g, 3'(e), 1'b0}, "R7 flags",
              reg_rdata, {1'b0, 3'(f) & ~g, 3'(e), 1'b0});
          chk(top_pc == 13'(f * 8 + e + 13'h100), "R7 push", top_pc, f * 8 + e + 'h100);
          cmd_reti;
          chk(top_pc == 0, "R9 pop", top_pc, 0);
        end else begin
          chk(reg_rdata == {1'b0, 3'(f), 3'(e), 1'b1}, "R5 hold",
              reg_rdata, {1'b0, 3'(f), 3'(e), 1'b1});
        end
      end
    end

    // R9 plain return keeps master off, reti sets it
    wr(8'h00); cmd_ret;
    chk(reg_rdata[0] == 0, "R9 ret", reg_rdata, 0);
    cmd_reti;
    chk(reg_rdata[0] == 1, "R9 reti", reg_rdata, 1);

    // R8 full stack blocks, return releases
    for (int i = 0; i < 16; i++) cmd_call(13'(i + 13'h200));
    wr(8'h13);
    phase_stb = 1; #1;
    chk(ack == 0, "R8 blocked", ack, 0);
    step; phase_stb = 0;
    chk(reg_rdata == 8'h13, "R8 kept", reg_rdata, 'h13);
    cmd_ret;
    chk(top_pc == 13'h20E, "R8 top", top_pc, 'h20E);
    pc_now = 13'h0AB; phase_stb = 1; #1;
    chk(ack == 1 && vec_addr == 13'h004, "R8 serve", vec_addr, 4);
    step; phase_stb = 0;
    chk(top_pc == 13'h0AB && reg_rdata == 8'h02, "R8 after", top_pc, 'hAB);

    // R10 seventeen calls drop oldest; R11 empty pops
    rst_n = 0; step; rst_n = 1; step;
    for (int i = 0; i < 17; i++) cmd_call(13'(i + 13'h300));
    for (int i = 16; i >= 1; i--) begin
      chk(top_pc == 13'(i + 13'h300), "R10 order", top_pc, i + 'h300);
      cmd_ret;
    end
    chk(top_pc == 0, "R10 oldest lost", top_pc, 0);
    cmd_ret;
    chk(top_pc == 0, "R11 empty", top_pc, 0);
    cmd_call(13'h1FFF);
    chk(top_pc == 13'h1FFF, "R11 no underflow", top_pc, 'h1FFF);
    cmd_ret;
    chk(top_pc == 0, "R11 empty again", top_pc, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule